// File: doc/BRIEF.md
# Selectable Buffer/Register Address Fanout

This block replicates one address word onto four identical output groups so that a single address source can feed four separate memory banks. A mode select picks where the groups take their value. In pass-through mode the groups follow the input with no clock involved. In held mode the groups show a value captured on the rising clock edge.

Two active-low enables each gate a pair of groups. A group that is shut off drives high impedance on its data bits and lowers its own enable flag, so a downstream model can see that the group is disabled without resolving Z. The capture register is independent of the select and of both enables. It loads on every clock edge, so a value can be staged while the groups are in pass-through mode or shut off, and it appears the moment held mode is selected.

Top module: `addr_fanout_reg`

## Requirements
- R1: Every group whose enable flag is high carries the same ADDR_W-bit value as every other enabled group.
- R2: While `mode_buf_i` is 1, each enabled group equals `addr_i` in the same cycle, with no clock edge needed.
- R3: While `mode_buf_i` is 0, each enabled group equals the value of `addr_i` sampled at the most recent rising edge of `clk`.
- R4: `oe_n_i[0]` gates groups 0 and 1 and `oe_n_i[1]` gates groups 2 and 3. A low enable bit sets those groups' flags in `grp_en_o` (bit g for group g) to 1.
- R5: A high enable bit clears the flags of its two groups to 0 and drives their data bits to Z.
- R6: The capture register loads `addr_i` on every rising edge whatever the values of `mode_buf_i` and `oe_n_i`.
- R7: A synchronous active-high `rst` clears the capture register to zero and does not affect the pass-through path.
- R8: Switching `mode_buf_i` from 1 to 0 presents the stored value at once, with no further clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of the capture register |
| mode_buf_i | input | 1 | 1 = pass-through, 0 = held value |
| oe_n_i | input | N_OE (2) | Active-low enables, one for each pair of groups |
| addr_i | input | ADDR_W (9) | Address word to replicate |
| grp_data_o | output | N_GRP*ADDR_W (36) | Group g occupies bits [g*ADDR_W +: ADDR_W]; Z when disabled |
| grp_en_o | output | N_GRP (4) | Per-group driving flag |

## Verification
The bench stages a value while both pairs are shut off in pass-through mode, then enables them and drops into held mode in the same cycle. A register that skipped loads while disabled or in pass-through mode would show a stale word, and one that needed an extra edge after the switch would show the old capture. It also asserts reset while in pass-through mode to catch a path that wrongly zeroes the live output. It steps through all four enable combinations, so a swapped or shared pair mapping shows up as wrong flags on the wrong groups.

// File: rtl/addr_fanout_pkg.sv
package addr_fanout_pkg;

  typedef enum logic {
    MODE_HELD = 1'b0,
    MODE_PASS = 1'b1
  } fan_mode_e;

  // Which active-low enable bit owns group g, given groups per enable.
  function automatic int enable_owner(input int g, input int groups_per_en);
    return g / groups_per_en;
  endfunction

endpackage

// File: rtl/afo_capture.sv
module afo_capture #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/afo_mode_sel.sv
module afo_mode_sel
  import addr_fanout_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         mode_buf,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] y
);

  fan_mode_e mode;

  always_comb begin
    mode = fan_mode_e'(mode_buf);
    y    = (mode == MODE_PASS) ? live : held;
  end

endmodule

// File: rtl/afo_group_drv.sv
module afo_group_drv #(
  parameter int W = 9
) (
  input  logic         oe_n,
  input  logic [W-1:0] val,
  output wire  [W-1:0] data,
  output logic         en
);

  assign en   = ~oe_n;
  assign data = en ? val : {W{1'bz}};

endmodule

// File: rtl/addr_fanout_reg.sv
module addr_fanout_reg
  import addr_fanout_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int N_GRP  = 4,
  parameter int N_OE   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_buf_i,
  input  logic [N_OE-1:0]         oe_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output wire  [N_GRP*ADDR_W-1:0] grp_data_o,
  output logic [N_GRP-1:0]        grp_en_o
);

  localparam int GPE = N_GRP / N_OE;

  // Named internal events for the checker.
  logic [ADDR_W-1:0] cap_q;
  logic [ADDR_W-1:0] sel_val;

  afo_capture #(.W(ADDR_W)) u_cap (
    .clk (clk),
    .rst (rst),
    .d   (addr_i),
    .q   (cap_q)
  );

  afo_mode_sel #(.W(ADDR_W)) u_sel (
    .mode_buf (mode_buf_i),
    .live     (addr_i),
    .held     (cap_q),
    .y        (sel_val)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int OWN = enable_owner(g, GPE);
    afo_group_drv #(.W(ADDR_W)) u_drv (
      .oe_n (oe_n_i[OWN]),
      .val  (sel_val),
      .data (grp_data_o[g*ADDR_W +: ADDR_W]),
      .en   (grp_en_o[g])
    );
  end

endmodule

// File: rtl/afo_checker.sv
module afo_checker #(
  parameter int ADDR_W = 9,
  parameter int N_GRP  = 4,
  parameter int N_OE   = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mode_buf_i,
  input logic [N_OE-1:0]         oe_n_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [ADDR_W-1:0]       cap_q,
  input logic [N_GRP*ADDR_W-1:0] grp_data_o,
  input logic [N_GRP-1:0]        grp_en_o
);

  localparam int GPE = N_GRP / N_OE;

  a_r6_loads_every_edge: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cap_q == $past(addr_i));

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> cap_q == '0);

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    a_r2_pass_follows: assert property (@(posedge clk) disable iff (rst)
      (mode_buf_i && grp_en_o[g]) |-> grp_data_o[g*ADDR_W +: ADDR_W] == addr_i);

    a_r3_held_shows_reg: assert property (@(posedge clk) disable iff (rst)
      (!mode_buf_i && grp_en_o[g]) |-> grp_data_o[g*ADDR_W +: ADDR_W] == cap_q);

    a_r4_flag_tracks_enable: assert property (@(posedge clk) disable iff (rst)
      grp_en_o[g] == !oe_n_i[g / GPE]);

    a_r1_groups_agree: assert property (@(posedge clk) disable iff (rst)
      (grp_en_o[g] && grp_en_o[0]) |->
        grp_data_o[g*ADDR_W +: ADDR_W] == grp_data_o[ADDR_W-1:0]);
  end

endmodule

bind addr_fanout_reg afo_checker #(
  .ADDR_W (ADDR_W),
  .N_GRP  (N_GRP),
  .N_OE   (N_OE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_buf_i (mode_buf_i),
  .oe_n_i     (oe_n_i),
  .addr_i     (addr_i),
  .cap_q      (cap_q),
  .grp_data_o (grp_data_o),
  .grp_en_o   (grp_en_o)
);

// File: tb/addr_fanout_reg_tb.sv
module addr_fanout_reg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 9;
  localparam int NG = 4;
  localparam int NO = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            mode_buf_i = 1'b0;
  logic [NO-1:0]   oe_n_i = '0;
  logic [W-1:0]    addr_i = '0;
  wire  [NG*W-1:0] grp_data_o;
  logic [NG-1:0]   grp_en_o;

  int n_checks = 0;
  int n_fail   = 0;
  int model_q  = 0;   // behavioural register: value seen at last edge

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_fanout_reg u_dut (
    .clk        (clk),
    .rst        (rst),
    .mode_buf_i (mode_buf_i),
    .oe_n_i     (oe_n_i),
    .addr_i     (addr_i),
    .grp_data_o (grp_data_o),
    .grp_en_o   (grp_en_o)
  );

  always @(posedge clk) model_q <= rst ? 0 : int'(addr_i);

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, then compare every group to the model.
  task automatic step(input logic sel, input logic [1:0] oen, input int a,
                      input logic r, input string ctx);
    int expv;
    @(negedge clk);
    mode_buf_i = sel; oe_n_i = oen; addr_i = W'(a); rst = r;
    #1;
    expv = sel ? a : model_q;
    for (int g = 0; g < NG; g++) begin
      int exp_en;
      exp_en = (oen[g/2] == 1'b0) ? 1 : 0;
      chk(exp_en ? {ctx, " R4 flag"} : {ctx, " R5 flag"}, int'(grp_en_o[g]), exp_en);
      if (exp_en == 1)
        chk(sel ? {ctx, " R2 data"} : {ctx, " R3 data"},
            int'(grp_data_o[g*W +: W]), expv);
    end
    if (grp_en_o[0] && grp_en_o[3])
      chk({ctx, " R1 agree"}, int'(grp_data_o[3*W +: W]), int'(grp_data_o[W-1:0]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    // Reset state in held mode: register cleared (R7).
    step(1'b0, 2'b00, 17, 1'b1, "R7 reset");
    step(1'b0, 2'b00, 99, 1'b1, "R7 reset");
    // Held mode with varied words (R3, R6).
    for (int i = 0; i < 24; i++)
      step(1'b0, 2'b00, (i * 37 + 5) % 512, 1'b0, "R6 held");
    step(1'b0, 2'b00, 511, 1'b0, "R3 max");
    step(1'b0, 2'b00, 0, 1'b0, "R3 zero");
    // Pass-through mode (R2).
    for (int i = 0; i < 24; i++)
      step(1'b1, 2'b00, (i * 91 + 300) % 512, 1'b0, "R2 pass");
    // All enable combinations in both modes (R4, R5).
    for (int e = 0; e < 4; e++) begin
      step(1'b1, 2'(e), 100 + e, 1'b0, "R4 pass oe");
      step(1'b0, 2'(e), 200 + e, 1'b0, "R4 held oe");
      step(1'b0, 2'(e), 300 + e, 1'b0, "R5 held oe");
    end
    // Reset in pass-through mode leaves live path alone (R7).
    step(1'b1, 2'b00, 333, 1'b1, "R7 pass rst");
    step(1'b1, 2'b00, 444, 1'b1, "R7 pass rst");
    // Register is zero after reset: held mode shows 0 immediately (R7, R8).
    step(1'b0, 2'b00, 12, 1'b0, "R7 R8 after rst");
    // Stage while shut off in pass-through mode, then switch (R6, R8).
    step(1'b1, 2'b11, 258, 1'b0, "R6 staged off");
    step(1'b1, 2'b11, 171, 1'b0, "R6 staged off");
    step(1'b0, 2'b00, 5, 1'b0, "R8 switch");
    step(1'b0, 2'b00, 6, 1'b0, "R3 next");
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 2'(i % 4), (i * 53 + 7) % 512, 1'b0, "R8 toggle");
      step(1'b0, 2'b00, (i * 29 + 1) % 512, 1'b0, "R8 toggle");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule